// File: doc/BRIEF.md
# Host Expand Data Offset Unpacker

This block turns a stream of 32-bit host words into a stream of small elements, one per cycle. It serves operations that expand host data. There are three element types: 1-bit monochrome pixels, 4-bit alpha values and 8-bit alpha values. The first useful element of an operation need not sit at the start of the first host word. Its position comes from the low bits of the linear source address, and the meaning of those bits depends on the element type.

An operation starts with a one-cycle `start` pulse. The pulse latches the mode, the address low bits and the element count. The block then pulls host words through a valid/ready input and pushes elements through a valid/ready output. It asks for a new word only when the current word has no elements left. After the programmed number of elements it drops the rest of the last word and pulses `done`. The address and mode inputs are only sampled by the pulse, so the register behind them keeps its programmed value and can change freely during the operation.

Top module: `host_unpack`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `in_ready`, `out_valid`, `out_last` and `done` are all 0.
- R2: Mode 2'b00 (1-bit): the element at stream position p comes from word p/32, byte b=(p%32)/8, data bit 8*b+7-(p%8). This means byte 0 comes first and each byte is read from its most significant bit down. The first position is `src_ofs[4:0]`, where bits [4:3] pick the byte and bits [2:0] pick the bit.
- R3: Mode 2'b01 (4-bit): element n of a word is data bits [4n+3:4n], low nibble first. The first position is `src_ofs[3:0]`. A value of 8 or more discards the whole first word without output and starts in the second word at position `src_ofs[2:0]`.
- R4: Mode 2'b10 (8-bit): element n of a word is data bits [8n+7:8n]. The first position is `src_ofs[2:0]`. A value of 4 or more discards the first word and starts in the second word at position `src_ofs[1:0]`.
- R5: Address bits above the slice used by the current mode have no effect on the output.
- R6: Only the first element of the operation is offset. Every word after the one holding it is read from element 0.
- R7: Exactly `count` elements are emitted, and `out_last` marks the final one. The number of host words taken is (offset+count-1)/per_word+1, and the rest of the last word is dropped.
- R8: `done` is high for exactly one cycle, the cycle after the final element handshake, and `busy` is low in that cycle.
- R9: `in_ready` is high only while the block is busy and holds no unread element.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_elem` holds its value.
- R11: A `start` pulse while busy is ignored. A `start` pulse with `count`=0 pulses `done` in the next cycle and takes no host word.
- R12: `mode`, `src_ofs` and `count` are sampled only when an operation starts. Changing them later does not change that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| mode | input | 2 | Element type: 00 1-bit, 01 4-bit, 10 8-bit, 11 treated as 8-bit |
| src_ofs | input | 5 | Low bits of the linear source address |
| count | input | CNT_W | Number of elements to emit |
| in_valid | input | 1 | Host word available |
| in_ready | output | 1 | Block accepts a host word |
| in_data | input | 32 | Host word |
| out_valid | output | 1 | Element available |
| out_ready | input | 1 | Consumer accepts the element |
| out_elem | output | 8 | Element, zero-extended to 8 bits |
| out_last | output | 1 | Current element is the last of the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions check the handshake rules on every cycle. These are: input ready is gated by busy and by an empty holding word, the output holds under backpressure, `done` is a single cycle and only comes while idle, the last flag only appears with valid data, and a start pulse cannot disturb a running operation. They cannot check which bit, nibble or byte comes out, how many words are taken, or how the address slice depends on the mode. Only the bench scenarios show those, by comparing each element against a position model of the host words. The model covers each mode, offsets that skip the first word, ignored upper address bits, backpressure, and inputs that change in the middle of an operation.

// File: rtl/host_unpack.sv
module host_unpack #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [4:0]       src_ofs,
  input  logic [CNT_W-1:0] count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_elem,
  output logic             out_last,
  output logic             busy,
  output logic             done
);
  localparam logic [1:0] M_BIT = 2'b00;
  localparam logic [1:0] M_NIB = 2'b01;

  logic             busy_q, have_q, first_q, skip_q, done_q;
  logic [1:0]       md_q;
  logic [4:0]       idx_q, first_idx_q;
  logic [CNT_W-1:0] rem_q;
  logic [31:0]      word_q;

  logic [4:0] start_idx, last_idx;
  logic       start_skip;
  logic       in_hs, out_hs;

  always_comb begin
    case (mode)
      M_BIT:   begin start_idx = src_ofs;                start_skip = 1'b0;       end
      M_NIB:   begin start_idx = {2'b00, src_ofs[2:0]};  start_skip = src_ofs[3]; end
      default: begin start_idx = {3'b000, src_ofs[1:0]}; start_skip = src_ofs[2]; end
    endcase
  end

  always_comb begin
    case (md_q)
      M_BIT:   last_idx = 5'd31;
      M_NIB:   last_idx = 5'd7;
      default: last_idx = 5'd3;
    endcase
  end

  always_comb begin
    case (md_q)
      M_BIT:   out_elem = {7'b0, word_q[{idx_q[4:3], ~idx_q[2:0]}]};
      M_NIB:   out_elem = {4'b0, word_q[{idx_q[2:0], 2'b00} +: 4]};
      default: out_elem = word_q[{idx_q[1:0], 3'b000} +: 8];
    endcase
  end

  assign in_ready  = busy_q && !have_q;
  assign out_valid = have_q;
  assign out_last  = have_q && (rem_q == CNT_W'(1));
  assign busy      = busy_q;
  assign done      = done_q;
  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      have_q      <= 1'b0;
      first_q     <= 1'b0;
      skip_q      <= 1'b0;
      done_q      <= 1'b0;
      md_q        <= M_BIT;
      idx_q       <= '0;
      first_idx_q <= '0;
      rem_q       <= '0;
      word_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (count == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q      <= 1'b1;
            md_q        <= mode;
            rem_q       <= count;
            first_q     <= 1'b1;
            first_idx_q <= start_idx;
            skip_q      <= start_skip;
          end
        end
      end else begin
        if (in_hs) begin
          if (skip_q) begin
            skip_q <= 1'b0;
          end else begin
            word_q  <= in_data;
            have_q  <= 1'b1;
            idx_q   <= first_q ? first_idx_q : 5'd0;
            first_q <= 1'b0;
          end
        end
        if (out_hs) begin
          if (rem_q == CNT_W'(1)) begin
            have_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            rem_q <= rem_q - CNT_W'(1);
            if (idx_q == last_idx) have_q <= 1'b0;
            else                   idx_q  <= idx_q + 5'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/host_unpack_chk.sv
module host_unpack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_elem,
  input logic       out_last,
  input logic       done
);
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy && !out_valid); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_elem)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !in_ready); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(out_valid && out_ready && out_last) |=> busy && !done); // R11
endmodule

bind host_unpack host_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_elem(out_elem),
  .out_last(out_last), .done(done)
);

// File: tb/host_unpack_test.sv
module host_unpack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  src_ofs = 5'd0;
  logic [15:0] count = 16'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_elem;
  logic        out_last;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  host_unpack #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .src_ofs(src_ofs),
    .count(count), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_elem(out_elem),
    .out_last(out_last), .busy(busy), .done(done)
  );

  localparam logic [31:0] WORDS [8] = '{
    32'hA5C3_1E96, 32'h3C7F_0D82, 32'hE14B_96F0, 32'h5A2D_C378,
    32'h0FF1_8E24, 32'hB6D9_4A17, 32'h7123_CDE5, 32'h9E6B_2F41};

  // {mode[1:0], src_ofs[4:0], count[15:0]}
  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 5'd0,  16'd32},  // R2 whole word
    {2'b00, 5'd13, 16'd40},  // R2 R6 crosses word
    {2'b00, 5'd31, 16'd3},   // R2 last bit then next word
    {2'b00, 5'd7,  16'd1},   // R7 single element
    {2'b01, 5'd3,  16'd12},  // R3 R6
    {2'b01, 5'd9,  16'd5},   // R3 skip first word
    {2'b01, 5'd19, 16'd6},   // R5 upper bit ignored
    {2'b10, 5'd2,  16'd7},   // R4 R6
    {2'b10, 5'd6,  16'd4},   // R4 skip first word
    {2'b10, 5'd25, 16'd5},   // R5 upper bits ignored
    {2'b11, 5'd1,  16'd6}    // 11 behaves as 8-bit
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int per_word(input logic [1:0] m);
    return (m == 2'b00) ? 32 : (m == 2'b01) ? 8 : 4;
  endfunction

  function automatic int eff_ofs(input logic [1:0] m, input logic [4:0] o);
    return (m == 2'b00) ? int'(o) : (m == 2'b01) ? int'(o[3:0]) : int'(o[2:0]);
  endfunction

  function automatic int exp_elem(input logic [1:0] m, input logic [4:0] o, input int k);
    int p, w, e;
    logic [31:0] d;
    p = eff_ofs(m, o) + k;
    w = p / per_word(m);
    e = p % per_word(m);
    d = WORDS[w];
    if (m == 2'b00) return int'(d[(e / 8) * 8 + 7 - (e % 8)]);
    if (m == 2'b01) return int'(d[4 * e +: 4]);
    return int'(d[8 * e +: 8]);
  endfunction

  task automatic run_op(input logic [1:0] m, input logic [4:0] o, input int cnt,
                        input bit bp, input bit garble);
    int k = 0, wi = 0, cyc = 0, last_cyc = -10, done_cyc = -1, ndone = 0;
    int exp_words;
    @(negedge clk);
    mode = m; src_ofs = o; count = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_words = (eff_ofs(m, o) + cnt - 1) / per_word(m) + 1;
    while (cyc < 400) begin
      in_valid  = (wi < 8);
      in_data   = WORDS[(wi < 8) ? wi : 0];
      out_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (garble) begin
        mode = ~m; src_ofs = 5'd30; count = 16'd2;
        start = (cyc == 3);
      end
      #1;
      if (done) begin
        ndone++;
        if (done_cyc < 0) done_cyc = cyc;
        chk(!busy, "R8 busy low with done", int'(busy), 0);
      end
      if (in_valid && in_ready) wi++;
      if (out_valid && out_ready) begin
        if (k < cnt) begin
          chk(int'(out_elem) == exp_elem(m, o, k), "R2/R3/R4/R6 element value",
              int'(out_elem), exp_elem(m, o, k));
          chk(out_last == (k == cnt - 1), "R7 last flag", int'(out_last), int'(k == cnt - 1));
        end
        k++;
        last_cyc = cyc;
      end
      if (done_cyc >= 0 && cyc > done_cyc + 1) break;
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b0; start = 1'b0;
    chk(k == cnt, "R7 element count", k, cnt);
    chk(wi == exp_words, "R7 words taken", wi, exp_words);
    chk(done_cyc == last_cyc + 1, "R8 done timing", done_cyc, last_cyc + 1);
    chk(ndone == 1, "R8 single done", ndone, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !in_ready && !out_valid && !done && !out_last, "R1 in reset",
        int'({busy, in_ready, out_valid, done, out_last}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy && !in_ready && !out_valid && !done && !out_last, "R1 after reset",
        int'({busy, in_ready, out_valid, done, out_last}), 0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][22:21], VEC[i][20:16], int'(VEC[i][15:0]), 1'b0, 1'b0);

    run_op(2'b01, 5'd5, 11, 1'b1, 1'b0);   // R10 backpressure
    run_op(2'b00, 5'd20, 20, 1'b1, 1'b0);  // R10 R2
    run_op(2'b10, 5'd1, 9, 1'b0, 1'b1);    // R11 R12 inputs change mid-operation
    run_op(2'b00, 5'd3, 35, 1'b0, 1'b1);   // R11 R12

    // R11 zero count: done next cycle, no word taken
    @(negedge clk);
    mode = 2'b00; src_ofs = 5'd0; count = 16'd0; start = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done == 1'b1, "R11 zero count done", int'(done), 1);
    chk(!busy && !in_ready, "R11 zero count idle", int'({busy, in_ready}), 0);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R11 zero count single pulse", int'(done), 0);
    in_valid = 1'b0;

    // R9 idle: no word requested without an operation
    repeat (2) @(negedge clk);
    #1;
    chk(!in_ready && !out_valid, "R9 idle no request", int'({in_ready, out_valid}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule